// File: doc/BRIEF.md
# Set Dueling Policy Selector

This block decides, at run time, which of two insertion policies a set-associative cache should apply when it fills a line. A small sample of sets is fixed to LRU insertion, another small sample is fixed to bimodal insertion, and every other set follows whichever sample is currently missing less. For each access the cache presents its set index, and the block answers at once with the class of that set and the insertion policy the replacement logic must use for the fill.

A single saturating up/down counter forms the whole decision state. Misses in the fixed-LRU sample push it up, and misses in the fixed-bimodal sample push it down. Its top bit picks the policy for the follower sets. Hits, follower misses and cycles with no access leave it untouched. With the default parameters the index is 10 bits wide, each fixed sample holds 32 sets, and the counter is 10 bits wide, so the selection state stays under two bytes.

The access input is a stream of one-cycle pulses that carry a valid flag. The block accepts an access in every cycle and never applies back-pressure, so it has no ready signal. The classification outputs are combinational and are driven even when `acc_valid` is low.

Top module: `duel_policy_sel`

## Requirements
- R1: A set whose upper five index bits equal its lower five index bits is a fixed-LRU set, reported as `set_class` = 2'b01.
- R2: A set whose upper five index bits equal the bitwise complement of its lower five index bits is a fixed-bimodal set, reported as `set_class` = 2'b10.
- R3: Every other set is a follower, reported as `set_class` = 2'b00.
- R4: `use_bimodal` (1 = bimodal insertion, 0 = LRU insertion) is always 0 for fixed-LRU sets and always 1 for fixed-bimodal sets, whatever the counter holds.
- R5: After reset the counter holds its midpoint, 512, so followers start with bimodal insertion. A single fixed-bimodal miss then moves them to LRU insertion.
- R6: A valid miss to a fixed-LRU set raises the counter by one, and a valid miss to a fixed-bimodal set lowers it by one. The new value takes effect at the next rising clock edge.
- R7: The counter holds at 1023 instead of wrapping to 0, and holds at 0 instead of wrapping to 1023.
- R8: Hits, misses to follower sets, and any input seen while `acc_valid` is low leave the counter unchanged.
- R9: For a follower set, `use_bimodal` equals the counter's top bit in the same cycle as the access, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Access present this cycle |
| acc_set | input | 10 | Set index of the access |
| acc_miss | input | 1 | 1 when the access missed, 0 when it hit |
| set_class | output | 2 | 00 follower, 01 fixed-LRU, 10 fixed-bimodal |
| use_bimodal | output | 1 | Insertion policy for this access: 1 bimodal, 0 LRU |

## Verification
`set_class` and `use_bimodal` are due in the same cycle as the access. The bench therefore drives each access on the falling edge and compares both outputs against its model 1 ns later, before the next rising edge. A counter change caused by a miss becomes visible only after that rising edge. The bench updates its model integer at the same edge and then probes a follower set in the following cycle, so every counter step, and every saturation point, shows up as the follower policy one cycle after the miss that caused it.

// File: rtl/dps_pkg.sv
package dps_pkg;
  typedef enum logic [1:0] {
    SET_FOLLOW   = 2'b00,
    SET_LRU_LEAD = 2'b01,
    SET_BIM_LEAD = 2'b10
  } set_class_e;
endpackage

// File: rtl/dps_set_classifier.sv
module dps_set_classifier #(
  parameter int IDX_W = 10
) (
  input  logic [IDX_W-1:0] set_idx,
  output logic             is_lru,
  output logic             is_bim
);
  localparam int HALF = IDX_W / 2;

  logic [HALF-1:0] hi_part;
  logic [HALF-1:0] lo_part;

  assign hi_part = set_idx[IDX_W-1 -: HALF];
  assign lo_part = set_idx[HALF-1:0];
  assign is_lru  = (hi_part == lo_part);
  assign is_bim  = (hi_part == ~lo_part);

  // r3_: a set can never belong to both fixed samples
  always_comb begin
    p_disjoint_r3: assert (!(is_lru && is_bim) || $isunknown(set_idx));
  end
endmodule

// File: rtl/dps_sat_counter.sv
module dps_sat_counter #(
  parameter int W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic msb
);
  localparam logic [W-1:0] MAX_V = {W{1'b1}};
  localparam logic [W-1:0] MID_V = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= MID_V;
    end else if (inc && !dec && cnt != MAX_V) begin
      cnt <= cnt + W'(1);
    end else if (dec && !inc && cnt != '0) begin
      cnt <= cnt - W'(1);
    end
  end

  assign msb = cnt[W-1];

  p_step_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec && cnt != MAX_V) |=> cnt == $past(cnt) + W'(1));
  p_step_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc && cnt != '0) |=> cnt == $past(cnt) - W'(1));
  p_hold_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && cnt == MAX_V) |=> cnt == MAX_V);
  p_hold_bottom_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && cnt == '0) |=> cnt == '0);
  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !dec) |=> $stable(cnt));
endmodule

// File: rtl/duel_policy_sel.sv
module duel_policy_sel #(
  parameter int SET_IDX_W = 10,
  parameter int CNT_W     = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_valid,
  input  logic [SET_IDX_W-1:0] acc_set,
  input  logic                 acc_miss,
  output logic [1:0]           set_class,
  output logic                 use_bimodal
);
  import dps_pkg::*;

  logic       is_lru;
  logic       is_bim;
  logic       cnt_msb;
  logic       miss_ok;
  set_class_e cls;

  dps_set_classifier #(.IDX_W(SET_IDX_W)) u_class (
    .set_idx (acc_set),
    .is_lru  (is_lru),
    .is_bim  (is_bim)
  );

  assign miss_ok = acc_valid && acc_miss;

  dps_sat_counter #(.W(CNT_W)) u_psel (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (miss_ok && is_lru),
    .dec   (miss_ok && is_bim),
    .msb   (cnt_msb)
  );

  always_comb begin
    if (is_lru)      cls = SET_LRU_LEAD;
    else if (is_bim) cls = SET_BIM_LEAD;
    else             cls = SET_FOLLOW;
  end

  always_comb begin
    unique case (cls)
      SET_LRU_LEAD: use_bimodal = 1'b0;
      SET_BIM_LEAD: use_bimodal = 1'b1;
      default:      use_bimodal = cnt_msb;
    endcase
  end

  assign set_class = cls;

  p_lru_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_class == 2'b01) |-> !use_bimodal);
  p_bim_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_class == 2'b10) |-> use_bimodal);
  p_class_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_class));
endmodule

// File: tb/duel_policy_sel_tb.sv
module duel_policy_sel_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0;
  logic [9:0] acc_set = '0;
  logic       acc_miss = 1'b0;
  logic [1:0] set_class;
  logic       use_bimodal;

  int n_checks = 0;
  int n_fail = 0;
  int ref_cnt = 512;

  always #2 clk = ~clk;

  duel_policy_sel u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
    .acc_miss(acc_miss), .set_class(set_class), .use_bimodal(use_bimodal)
  );

  function automatic int exp_class(input int s);
    int hi, lo;
    hi = (s >> 5) & 31;
    lo = s & 31;
    if (hi == lo) return 1;
    if (hi == (31 - lo)) return 2;
    return 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic access(input int s, input bit v, input bit m, input string ftag);
    int c, pol;
    @(negedge clk);
    acc_valid = v; acc_set = s[9:0]; acc_miss = m;
    #1;
    c = exp_class(s);
    chk(c == 1 ? "R1 class" : (c == 2 ? "R2 class" : "R3 class"), set_class, c);
    pol = (c == 1) ? 0 : (c == 2) ? 1 : (ref_cnt >= 512 ? 1 : 0);
    chk(c == 0 ? ftag : "R4 fixed policy", use_bimodal, pol);
    @(posedge clk);
    if (v && m) begin
      if (c == 1 && ref_cnt < 1023) ref_cnt++;
      if (c == 2 && ref_cnt > 0)    ref_cnt--;
    end
  endtask

  task automatic probe(input string tag);
    access(1, 1'b1, 1'b0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R5: reset midpoint, followers bimodal
    probe("R5 reset policy");
    access(124, 1, 1, "R5 one bim miss");
    probe("R5 midpoint drop");
    access(165, 1, 1, "R6 lru miss");
    probe("R6 step up");
    // R1 R2 R3: classify every set via hits
    for (int s = 0; s < 1024; s++) access(s, 1, 0, "R9 follower");
    // R8: hits, follower misses, invalid misses leave counter at 512
    for (int i = 0; i < 4; i++) begin
      access(1 + i * 3, 1, 1, "R8 follower miss");
      access(124, 1, 0, "R8 bim hit");
      access(31, 0, 1, "R8 invalid bim miss");
      probe("R8 hold");
    end
    access(124, 1, 1, "R6 bim miss");
    probe("R8 no stray change");
    access(165, 1, 1, "R6 lru miss");
    probe("R6 back to mid");
    // R7 top saturation
    for (int i = 0; i < 700; i++) access((i % 2) ? 0 : 1023, 1, 1, "R7 climb");
    for (int i = 0; i < 514; i++) begin
      access((i % 2) ? 31 : 992, 1, 1, "R7 descend");
      probe("R7 top hold");
    end
    // R7 bottom saturation
    for (int i = 0; i < 800; i++) access(124, 1, 1, "R7 fall");
    for (int i = 0; i < 514; i++) begin
      access(165, 1, 1, "R6 rise");
      probe("R7 bottom hold");
    end
    // R9: same-cycle follower policy across several followers
    for (int s = 2; s < 40; s += 7) access(s, 1, 0, "R9 follower policy");
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule